// File: doc/BRIEF.md
# Boolean Bit Processor Unit

This unit carries out the single-bit instructions of an 8-bit microcontroller core. The decoder hands it an opcode byte, an already-resolved bit address and the current carry. The unit reads the addressed bit through a read port that it drives itself. It then produces three things: the next carry, an optional write of one bit back to bit-addressable storage, and a branch-taken indication for the bit-test jumps.

The supported operations are:
- clear, set and complement, applied either to the carry or to an addressed bit;
- AND and OR of the carry with a bit or with the bit's inverse;
- moves in both directions between the carry and a bit;
- the three bit-test jumps.

Two further rules apply. A read-modify-write access raises a strobe so that port storage returns its output latch and not the pin level. The flag register's top bit, bit address 215, is the carry itself, so a bit write there also updates the carry and a read there returns the live carry.

Results are registered. An operation presented with `op_valid` high before a rising clock edge shows its effects on `carry_out`, `bit_we`, `bit_wa`, `bit_wd` and `branch_taken` just after that edge. The read port (`rd_addr`, `rd_latch`) is combinational.

Top module: `bit_proc_unit`

## Requirements
- R1: While reset is asserted and after its release, before any operation, `carry_out`, `bit_we` and `branch_taken` are 0.
- R2: Opcode 0xC3 makes the carry 0, 0xD3 makes it 1 and 0xB3 inverts it; none of the three writes a bit.
- R3: Opcodes 0xC2, 0xD2 and 0xB2 write the addressed bit (`bit_wa` equal to the presented address) with 0, 1 or the inverse of the read bit respectively. For example, clearing bit 2 of a byte holding 0x5D leaves 0x59.
- R4: Opcode 0x82 (AND with bit) and 0xB0 (AND with inverse) clear the carry when their source value is 0 and otherwise leave it unchanged.
- R5: Opcode 0x72 (OR with bit) and 0xA0 (OR with inverse) set the carry when their source value is 1 and otherwise leave it unchanged.
- R6: The AND, OR and move-to-carry forms (0x82, 0xB0, 0x72, 0xA0, 0xA2) never write the addressed bit.
- R7: Opcode 0xA2 copies the read bit into the carry. Opcode 0x92 writes the carry into the addressed bit and leaves the carry unchanged.
- R8: Opcode 0x10 (jump if set, then clear) writes 0 to the bit and signals branch taken when the bit is 1. When the bit is 0 it does neither.
- R9: Opcode 0x20 signals branch taken when the bit is 1, and 0x30 when it is 0. Neither writes the bit.
- R10: Any bit write to address 215 sets the carry to the written value on the same edge. Any read of address 215 takes its value from `carry_in` and not from `rd_data`.
- R11: `rd_latch` is 1 exactly when `op_valid` is 1 and the opcode is 0xB2 or 0x10, the read-modify-write forms that read a bit.
- R12: When `op_valid` is 0, or when the opcode is none of those above, there is no write and no branch, and `carry_out` takes the value of `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 8 | Decoded opcode byte |
| bit_addr | input | 8 | Bit address of the operand |
| carry_in | input | 1 | Current carry flag |
| rd_addr | output | 8 | Read port address (follows `bit_addr`) |
| rd_latch | output | 1 | Read-modify-write read: return the output latch value |
| rd_data | input | 1 | Bit value returned by the read port |
| carry_out | output | 1 | Registered next carry |
| bit_we | output | 1 | Registered bit write enable |
| bit_wa | output | 8 | Registered bit write address |
| bit_wd | output | 1 | Registered bit write data |
| branch_taken | output | 1 | Registered branch-taken indication for 0x10, 0x20 and 0x30 |

## Verification
The assertions assume that `rd_data` answers the read of the address presented in the same cycle. They also assume that `op_valid` is held low throughout reset, because several properties look back one edge at the opcode and the carry. The stimulus keeps to both assumptions: the bench plays the role of the bit storage, supplies the read bit together with each operation, and drives `op_valid` low until reset has been released. The address-215 rows give `rd_data` a value that disagrees with `carry_in`, so that only the carry-coupling rule can produce the expected result.

// File: rtl/bit_proc_unit.sv
module bit_proc_unit #(
  parameter int              AW      = 8,
  parameter logic [AW-1:0]   CY_ADDR = 8'd215
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] bit_addr,
  input  logic          carry_in,
  output logic [AW-1:0] rd_addr,
  output logic          rd_latch,
  input  logic          rd_data,
  output logic          carry_out,
  output logic          bit_we,
  output logic [AW-1:0] bit_wa,
  output logic          bit_wd,
  output logic          branch_taken
);

  localparam logic [7:0] OP_JBC   = 8'h10;
  localparam logic [7:0] OP_JB    = 8'h20;
  localparam logic [7:0] OP_JNB   = 8'h30;
  localparam logic [7:0] OP_ORB   = 8'h72;
  localparam logic [7:0] OP_ANDB  = 8'h82;
  localparam logic [7:0] OP_STC   = 8'h92;
  localparam logic [7:0] OP_ORN   = 8'hA0;
  localparam logic [7:0] OP_LDC   = 8'hA2;
  localparam logic [7:0] OP_ANDN  = 8'hB0;
  localparam logic [7:0] OP_CPLB  = 8'hB2;
  localparam logic [7:0] OP_CPLC  = 8'hB3;
  localparam logic [7:0] OP_CLRB  = 8'hC2;
  localparam logic [7:0] OP_CLRC  = 8'hC3;
  localparam logic [7:0] OP_SETB  = 8'hD2;
  localparam logic [7:0] OP_SETC  = 8'hD3;

  logic src;
  logic c_n, we_n, wd_n, tk_n;
  logic live;

  assign rd_addr  = bit_addr;
  assign rd_latch = op_valid && (opcode == OP_CPLB || opcode == OP_JBC);
  assign src      = (bit_addr == CY_ADDR) ? carry_in : rd_data;

  always_comb begin
    c_n  = carry_in;
    we_n = 1'b0;
    wd_n = 1'b0;
    tk_n = 1'b0;
    if (op_valid) begin
      unique case (opcode)
        OP_CLRC: c_n = 1'b0;
        OP_SETC: c_n = 1'b1;
        OP_CPLC: c_n = ~carry_in;
        OP_CLRB: begin we_n = 1'b1; wd_n = 1'b0; end
        OP_SETB: begin we_n = 1'b1; wd_n = 1'b1; end
        OP_CPLB: begin we_n = 1'b1; wd_n = ~src; end
        OP_ANDB: c_n = carry_in & src;
        OP_ANDN: c_n = carry_in & ~src;
        OP_ORB:  c_n = carry_in | src;
        OP_ORN:  c_n = carry_in | ~src;
        OP_LDC:  c_n = src;
        OP_STC:  begin we_n = 1'b1; wd_n = carry_in; end
        OP_JBC:  begin we_n = src; wd_n = 1'b0; tk_n = src; end
        OP_JB:   tk_n = src;
        OP_JNB:  tk_n = ~src;
        default: ;
      endcase
      if (we_n && bit_addr == CY_ADDR) c_n = wd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_out    <= 1'b0;
      bit_we       <= 1'b0;
      bit_wa       <= '0;
      bit_wd       <= 1'b0;
      branch_taken <= 1'b0;
      live         <= 1'b0;
    end else begin
      carry_out    <= c_n;
      bit_we       <= we_n;
      bit_wa       <= bit_addr;
      bit_wd       <= wd_n;
      branch_taken <= tk_n;
      live         <= 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !bit_we && !branch_taken && !carry_out);

  assert_and_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_valid && opcode == OP_ANDB && !carry_in) |-> !carry_out);

  assert_or_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_valid && opcode == OP_ORB && carry_in) |-> carry_out);

  assert_no_write_logic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_valid && (opcode == OP_ANDB || opcode == OP_ANDN ||
      opcode == OP_ORB || opcode == OP_ORN || opcode == OP_LDC)) |-> !bit_we);

  assert_jbc_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live && branch_taken && $past(opcode) == OP_JBC |-> bit_we && !bit_wd);

  assert_test_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_valid && (opcode == OP_JB || opcode == OP_JNB)) |-> !bit_we);

  assert_carry_coupled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we && bit_wa == CY_ADDR |-> carry_out == bit_wd);

  assert_latch_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |-> op_valid);

  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(op_valid) |-> !bit_we && !branch_taken && carry_out == $past(carry_in));

endmodule

// File: tb/bit_proc_unit_bench.sv
module bit_proc_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [7:0] opcode;
  logic [7:0] bit_addr;
  logic       carry_in;
  logic [7:0] rd_addr;
  logic       rd_latch;
  logic       rd_data;
  logic       carry_out;
  logic       bit_we;
  logic [7:0] bit_wa;
  logic       bit_wd;
  logic       branch_taken;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bit_proc_unit u_bit_proc_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .bit_addr(bit_addr), .carry_in(carry_in), .rd_addr(rd_addr),
    .rd_latch(rd_latch), .rd_data(rd_data), .carry_out(carry_out),
    .bit_we(bit_we), .bit_wa(bit_wa), .bit_wd(bit_wd),
    .branch_taken(branch_taken)
  );

  // {req, opcode, address, {carry_in, rd_data}, {carry, we, wd, taken}}
  localparam int NV = 32;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2,  8'hC3, 8'h00, 2'b10, 4'b0000},  // R2 clear carry
    {4'd2,  8'hD3, 8'h00, 2'b00, 4'b1000},  // R2 set carry
    {4'd2,  8'hB3, 8'h00, 2'b11, 4'b0000},  // R2 complement carry
    {4'd3,  8'hC2, 8'h12, 2'b11, 4'b1100},  // R3 clear bit
    {4'd3,  8'hD2, 8'h12, 2'b00, 4'b0110},  // R3 set bit
    {4'd3,  8'hB2, 8'h12, 2'b01, 4'b0100},  // R3 complement bit
    {4'd4,  8'h82, 8'h20, 2'b10, 4'b0000},  // R4 and, bit 0
    {4'd4,  8'h82, 8'h20, 2'b11, 4'b1000},  // R4 and, bit 1
    {4'd4,  8'h82, 8'h20, 2'b01, 4'b0000},  // R4 and, carry 0
    {4'd6,  8'hB0, 8'h20, 2'b11, 4'b0000},  // R6 R4 and inverse
    {4'd4,  8'hB0, 8'h20, 2'b10, 4'b1000},  // R4 and inverse, bit 0
    {4'd5,  8'h72, 8'h30, 2'b01, 4'b1000},  // R5 or, bit 1
    {4'd5,  8'h72, 8'h30, 2'b00, 4'b0000},  // R5 or, bit 0
    {4'd6,  8'hA0, 8'h30, 2'b00, 4'b1000},  // R6 R5 or inverse
    {4'd5,  8'hA0, 8'h30, 2'b01, 4'b0000},  // R5 or inverse, bit 1
    {4'd5,  8'hA0, 8'h30, 2'b11, 4'b1000},  // R5 or inverse, carry kept
    {4'd7,  8'hA2, 8'h40, 2'b01, 4'b1000},  // R7 bit to carry
    {4'd7,  8'hA2, 8'h40, 2'b10, 4'b0000},  // R7 bit to carry
    {4'd7,  8'h92, 8'h40, 2'b10, 4'b1110},  // R7 carry to bit
    {4'd7,  8'h92, 8'h40, 2'b01, 4'b0100},  // R7 carry to bit
    {4'd8,  8'h10, 8'h50, 2'b01, 4'b0101},  // R8 set: clear and jump
    {4'd8,  8'h10, 8'h50, 2'b10, 4'b1000},  // R8 clear: nothing
    {4'd9,  8'h20, 8'h50, 2'b01, 4'b0001},  // R9 jump if set
    {4'd9,  8'h20, 8'h50, 2'b00, 4'b0000},  // R9
    {4'd9,  8'h30, 8'h50, 2'b10, 4'b1001},  // R9 jump if clear
    {4'd9,  8'h30, 8'h50, 2'b11, 4'b1000},  // R9
    {4'd10, 8'hC2, 8'hD7, 2'b11, 4'b0100},  // R10 clear flag bit 7
    {4'd10, 8'hD2, 8'hD7, 2'b00, 4'b1110},  // R10 set flag bit 7
    {4'd10, 8'hB2, 8'hD7, 2'b10, 4'b0100},  // R10 complement reads carry
    {4'd10, 8'hA2, 8'hD7, 2'b10, 4'b1000},  // R10 move reads carry
    {4'd12, 8'h00, 8'h12, 2'b11, 4'b1000},  // R12 unlisted opcode
    {4'd12, 8'hE4, 8'h12, 2'b01, 4'b0000}   // R12 unlisted opcode
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; opcode = 8'h00; bit_addr = 8'h00;
    carry_in = 1'b1; rd_data = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "carry in reset", int'(carry_out), 0);
    chk("R1", "write in reset", int'(bit_we), 0);
    chk("R1", "branch in reset", int'(branch_taken), 0);
    rst_n = 1'b1;
    carry_in = 1'b0;
    @(negedge clk);
    chk("R1", "write after reset", int'(bit_we), 0);
    chk("R1", "branch after reset", int'(branch_taken), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VEC[i][25:22], i);
      op_valid = 1'b1;
      opcode   = VEC[i][21:14];
      bit_addr = VEC[i][13:6];
      carry_in = VEC[i][5];
      rd_data  = VEC[i][4];
      #1;
      chk(tag, "rd_addr", int'(rd_addr), int'(VEC[i][13:6]));
      @(posedge clk);
      @(negedge clk);
      chk(tag, "carry", int'(carry_out), int'(VEC[i][3]));
      chk(tag, "write enable", int'(bit_we), int'(VEC[i][2]));
      chk(tag, "branch", int'(branch_taken), int'(VEC[i][0]));
      if (VEC[i][2]) begin
        chk(tag, "write data", int'(bit_wd), int'(VEC[i][1]));
        chk(tag, "write address", int'(bit_wa), int'(VEC[i][13:6]));
      end
    end

    // R3: clear bit 2 of a byte holding 0x5D gives 0x59
    begin
      logic [7:0] byte_q;
      byte_q = 8'h5D;
      op_valid = 1'b1; opcode = 8'hC2; bit_addr = 8'h92; carry_in = 1'b0;
      rd_data = byte_q[2];
      @(posedge clk);
      @(negedge clk);
      if (bit_we) byte_q[bit_wa[2:0]] = bit_wd;
      chk("R3", "byte after clear", int'(byte_q), 8'h59);
    end

    // R11: latch strobe on read-modify-write forms only
    op_valid = 1'b1; opcode = 8'hB2; #1;
    chk("R11", "latch on complement bit", int'(rd_latch), 1);
    opcode = 8'h10; #1;
    chk("R11", "latch on jump-and-clear", int'(rd_latch), 1);
    opcode = 8'h20; #1;
    chk("R11", "no latch on jump if set", int'(rd_latch), 0);
    opcode = 8'h82; #1;
    chk("R11", "no latch on and", int'(rd_latch), 0);
    op_valid = 1'b0; opcode = 8'hB2; #1;
    chk("R11", "no latch when idle", int'(rd_latch), 0);

    // R12: idle cycle with a carry opcode present has no effect
    @(negedge clk);
    op_valid = 1'b0; opcode = 8'hD2; bit_addr = 8'hD7; carry_in = 1'b0; rd_data = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "idle carry", int'(carry_out), 0);
    chk("R12", "idle write", int'(bit_we), 0);
    opcode = 8'h20; carry_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "idle carry follows", int'(carry_out), 1);
    chk("R12", "idle branch", int'(branch_taken), 0);

    finish_run();
  end
endmodule